// File: doc/BRIEF.md
# Two-Carriage Shared-Track Place Controller

This block sequences two carriages that share one common section of track. Its state is a set of thirteen place bits, one flip-flop per place, and any number of them may be marked at once. Each transition is a small term of combinational logic. A transition fires when every one of its input places is marked and its condition on the start buttons and position sensors holds. On the clock edge that follows, it clears its input places and marks its output places. All transitions that are enabled fire on the same edge.

Each carriage has its own ring of six places. A single resource place, p7, stands for the free common track. A carriage has to take that token before it enters the common section and gives it back when it leaves. Carriage 1 wins the token whenever both carriages want it in the same cycle. The motor commands for each carriage are decoded directly from the marked places. The whole marking is also brought out, so the surrounding logic can observe the state.

Top module: `carriage_track_ctrl`

## Requirements
- R1: A synchronous reset, active high, loads the home marking: p1, p7 and p8 are set and all other places are clear. Bit i of `mark` holds place p(i+1), so the home marking reads 13'h0C1. All four motor outputs are low after reset.
- R2: Exactly one of the places p1 to p6 (carriage 1) is marked in every cycle.
- R3: Exactly one of the places p8 to p13 (carriage 2) is marked in every cycle.
- R4: Exactly one of p7, p4, p5, p11 and p12 is marked in every cycle, so at most one carriage is on the common track.
- R5: A transition whose input places and condition hold on a clock edge changes the marking on that edge. The new marking is visible one cycle after the inputs are applied.
- R6: A transition whose condition is false does not fire, and its input places stay marked. With neither start button pressed, the home marking holds whatever the sensors show.
- R7: Carriage 1 moves through its places in this order: p1 on btn1 to p2, p2 on D to p3, p3 with p7 to p4 (no condition), p4 on B to p5, p5 on D to p6 with p7 returned, and p6 on A back to p1.
- R8: Carriage 2 moves through its places in this order: p8 on btn2 to p9, p9 on E to p10, p10 with p7 and D low to p11, p11 on B to p12, p12 on E to p13 with p7 returned, and p13 on C back to p8.
- R9: A carriage in p10 waits while p7 is held by carriage 1. It enters p11 only after carriage 1 has passed D on its way back.
- R10: When p3, p10 and p7 are all marked and D is low, carriage 1 takes p7: the next marking has p4, and p10 is still marked.
- R11: The p10 transition is blocked while D is high, even when p7 is free.
- R12: Carriage 1 drives `car1_right` in p2 and p4 and `car1_left` in p5 and p6. Carriage 2 drives `car2_left` in p9 and p11 and `car2_right` in p12 and p13. Each output is low in every other place.
- R13: Transitions of the two carriages that are enabled on the same edge all fire on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn1 | input | 1 | Start request for carriage 1 |
| btn2 | input | 1 | Start request for carriage 2 |
| pos_a | input | 1 | Sensor at point A |
| pos_b | input | 1 | Sensor at point B |
| pos_c | input | 1 | Sensor at point C |
| pos_d | input | 1 | Sensor at point D |
| pos_e | input | 1 | Sensor at point E |
| car1_left | output | 1 | Carriage 1 moves left |
| car1_right | output | 1 | Carriage 1 moves right |
| car2_left | output | 1 | Carriage 2 moves left |
| car2_right | output | 1 | Carriage 2 moves right |
| mark | output | 13 | Current marking, bit i = place p(i+1) |

## Verification
The bench builds the block with its default home marking, 13'h0C1. With that marking every scenario starts from both carriages idle and the common track free. From there, directed sequences take each carriage alone around its full ring and start both carriages on the same edge. One sequence parks carriage 2 at p10 while carriage 1 holds the token, which brings the same-cycle contest for p7 within reach. The same sequence also reaches the edge on which carriage 1 arrives home while carriage 2 takes the token.

// File: rtl/carriage_track_ctrl.sv
module carriage_track_ctrl #(
  parameter int NPLACE = 13,
  parameter logic [NPLACE-1:0] HOME = 13'h0C1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              btn1,
  input  logic              btn2,
  input  logic              pos_a,
  input  logic              pos_b,
  input  logic              pos_c,
  input  logic              pos_d,
  input  logic              pos_e,
  output logic              car1_left,
  output logic              car1_right,
  output logic              car2_left,
  output logic              car2_right,
  output logic [NPLACE-1:0] mark
);
  logic [NPLACE-1:0] p_q, take, give;
  logic f1, f2, f3, f4, f5, f6, f7, f8, f9, f10, f11, f12;

  // carriage 1 ring
  assign f1  = p_q[0] & btn1;
  assign f2  = p_q[1] & pos_d;
  assign f3  = p_q[2] & p_q[6];
  assign f4  = p_q[3] & pos_b;
  assign f5  = p_q[4] & pos_d;
  assign f6  = p_q[5] & pos_a;
  // carriage 2 ring; the token goes to carriage 1 first
  assign f7  = p_q[7] & btn2;
  assign f8  = p_q[8] & pos_e;
  assign f9  = p_q[6] & p_q[9] & ~pos_d & ~f3;
  assign f10 = p_q[10] & pos_b;
  assign f11 = p_q[11] & pos_e;
  assign f12 = p_q[12] & pos_c;

  always_comb begin
    take = '0;
    give = '0;
    take[0]  = f1;        give[1]  = f1;
    take[1]  = f2;        give[2]  = f2;
    take[2]  = f3;        give[3]  = f3;
    take[3]  = f4;        give[4]  = f4;
    take[4]  = f5;        give[5]  = f5;
    take[5]  = f6;        give[0]  = f6;
    take[7]  = f7;        give[8]  = f7;
    take[8]  = f8;        give[9]  = f8;
    take[9]  = f9;        give[10] = f9;
    take[10] = f10;       give[11] = f10;
    take[11] = f11;       give[12] = f11;
    take[12] = f12;       give[7]  = f12;
    take[6]  = f3 | f9;
    give[6]  = f5 | f11;
  end

  always_ff @(posedge clk) begin
    if (rst) p_q <= HOME;
    else     p_q <= (p_q & ~take) | give;
  end

  assign car1_right = p_q[1] | p_q[3];
  assign car1_left  = p_q[4] | p_q[5];
  assign car2_left  = p_q[8] | p_q[10];
  assign car2_right = p_q[11] | p_q[12];
  assign mark       = p_q;
endmodule

// File: rtl/carriage_track_chk.sv
module carriage_track_chk #(
  parameter int NPLACE = 13,
  parameter logic [NPLACE-1:0] HOME = 13'h0C1
) (
  input logic              clk,
  input logic              rst,
  input logic              btn1,
  input logic              pos_d,
  input logic [NPLACE-1:0] mark
);
  assert_home_R1: assert property (@(posedge clk) $past(rst) |-> mark == HOME);

  assert_car1_one_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(mark[5:0]) == 1);

  assert_car2_one_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(mark[12:7]) == 1);

  assert_track_excl_R4: assert property (@(posedge clk) disable iff (rst)
    $countones({mark[6], mark[3], mark[4], mark[10], mark[11]}) == 1);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    mark[0] && !btn1 |=> mark[0]);

  assert_prio_R10: assert property (@(posedge clk) disable iff (rst)
    mark[2] && mark[9] && mark[6] && !pos_d |=> mark[3] && mark[9]);

  assert_d_block_R11: assert property (@(posedge clk) disable iff (rst)
    mark[9] && pos_d |=> mark[9]);
endmodule

bind carriage_track_ctrl carriage_track_chk #(.NPLACE(NPLACE), .HOME(HOME)) u_chk (
  .clk(clk), .rst(rst), .btn1(btn1), .pos_d(pos_d), .mark(mark)
);

// File: tb/tb_carriage_track_ctrl.sv
module tb_carriage_track_ctrl;
  logic clk = 0, rst = 1;
  logic btn1 = 0, btn2 = 0, pos_a = 0, pos_b = 0, pos_c = 0, pos_d = 0, pos_e = 0;
  logic car1_left, car1_right, car2_left, car2_right;
  logic [12:0] mark;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  carriage_track_ctrl dut (
    .clk(clk), .rst(rst), .btn1(btn1), .btn2(btn2),
    .pos_a(pos_a), .pos_b(pos_b), .pos_c(pos_c), .pos_d(pos_d), .pos_e(pos_e),
    .car1_left(car1_left), .car1_right(car1_right),
    .car2_left(car2_left), .car2_right(car2_right), .mark(mark)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_in(input logic b1, b2, a, b, c, d, e);
    btn1 = b1; btn2 = b2; pos_a = a; pos_b = b; pos_c = c; pos_d = d; pos_e = e;
  endtask

  task automatic expect_state(input logic [12:0] exp, input string tag);
    logic [3:0] eo, ao;
    checks++;
    if (mark !== exp) begin
      fails++;
      $display("FAIL %s mark actual=%h expected=%h", tag, mark, exp);
    end
    // R12 decode: {c1R, c1L, c2L, c2R}
    eo = {exp[1] | exp[3], exp[4] | exp[5], exp[8] | exp[10], exp[11] | exp[12]};
    ao = {car1_right, car1_left, car2_left, car2_right};
    checks++;
    if (ao !== eo) begin
      fails++;
      $display("FAIL R12 (%s) outputs actual=%b expected=%b", tag, ao, eo);
    end
  endtask

  task automatic do_reset();
    rst = 1; set_in(0,0,0,0,0,0,0);
    step(); step();
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_state(13'h0C1, "R1 home marking");
  endtask

  task automatic t_hold();
    do_reset();
    set_in(0,0,1,1,1,1,1);
    step(); step(); step();
    expect_state(13'h0C1, "R6 sensors without buttons");
  endtask

  task automatic t_car1();
    do_reset();
    set_in(1,0,0,0,0,0,0); step(); expect_state(13'h0C2, "R5 p1->p2");
    set_in(0,0,0,0,0,0,0); step(); expect_state(13'h0C2, "R6 p2 waits D");
    set_in(0,0,0,0,0,1,0); step(); expect_state(13'h0C4, "R7 p2->p3");
    set_in(0,0,0,0,0,0,0); step(); expect_state(13'h088, "R7 p3+p7->p4");
    set_in(0,0,0,1,0,0,0); step(); expect_state(13'h090, "R7 p4->p5");
    set_in(0,0,0,0,0,1,0); step(); expect_state(13'h0E0, "R7 p5->p6+p7");
    set_in(0,0,1,0,0,0,0); step(); expect_state(13'h0C1, "R7 p6->p1");
  endtask

  task automatic t_car2();
    do_reset();
    set_in(0,1,0,0,0,1,0); step(); expect_state(13'h141, "R8 p8->p9");
    set_in(0,0,0,0,0,1,1); step(); expect_state(13'h241, "R8 p9->p10");
    set_in(0,0,0,0,0,1,0); step(); step(); expect_state(13'h241, "R11 D high blocks");
    set_in(0,0,0,0,0,0,0); step(); expect_state(13'h401, "R8 p10+p7->p11");
    set_in(0,0,0,1,0,0,0); step(); expect_state(13'h801, "R8 p11->p12");
    set_in(0,0,0,0,0,0,1); step(); expect_state(13'h1041, "R8 p12->p13+p7");
    set_in(0,0,0,0,1,0,0); step(); expect_state(13'h0C1, "R8 p13->p8");
  endtask

  task automatic t_contest();
    do_reset();
    set_in(0,1,0,0,0,1,0); step();
    set_in(0,0,0,0,0,1,1); step(); expect_state(13'h241, "R9 car2 parked p10");
    set_in(1,0,0,0,0,1,0); step(); expect_state(13'h242, "R13 car1 starts, car2 parked");
    set_in(0,0,0,0,0,1,0); step(); expect_state(13'h244, "R11 p3 and p10 both wait");
    set_in(0,0,0,0,0,0,0); step(); expect_state(13'h208, "R10 carriage 1 wins p7");
    step(); step(); expect_state(13'h208, "R9 car2 waits while p7 held");
    set_in(0,0,0,1,0,0,0); step(); expect_state(13'h210, "R9 car1 p5, car2 waits");
    set_in(0,0,0,0,0,1,0); step(); expect_state(13'h260, "R9 p7 back, D still high");
    set_in(0,0,1,0,0,0,0); step(); expect_state(13'h401, "R13 p6->p1 and p10->p11 together");
    set_in(0,0,0,1,0,0,0); step(); expect_state(13'h801, "R8 p12");
    set_in(0,0,0,0,0,0,1); step();
    set_in(0,0,0,0,1,0,0); step(); expect_state(13'h0C1, "R8 back home");
  endtask

  task automatic t_both_start();
    do_reset();
    set_in(1,1,0,0,0,0,0); step(); expect_state(13'h142, "R13 both start together");
    set_in(0,0,0,0,0,1,0); step(); expect_state(13'h144, "R7 p3 while car2 in p9");
    set_in(0,0,0,0,0,0,0); step(); expect_state(13'h108, "R4 car1 holds track");
    set_in(0,0,0,1,0,0,0); step();
    set_in(0,0,0,0,0,1,0); step();
    set_in(0,0,1,0,0,0,0); step(); expect_state(13'h141, "R7 car1 home, car2 p9");
    set_in(0,0,0,0,0,0,1); step(); expect_state(13'h241, "R8 p10");
    set_in(0,0,0,0,0,0,0); step(); expect_state(13'h401, "R8 p11");
  endtask

  initial begin
    t_reset();
    t_hold();
    t_car1();
    t_car2();
    t_contest();
    t_both_start();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule